// File: doc/BRIEF.md
# Regulator control register target on a two-wire serial bus

This block is the register-access front end for a programmable step-down regulator. It listens on a two-wire serial bus as a 7-bit-addressed target at address 0x60. It holds six register slots: two output-voltage setpoints, one control register, two fixed identification bytes and one status byte. The SCL and SDA pins are oversampled by the system clock, and the block returns an active-high pull-down enable that the pad uses to drive SDA low.

A host writes one register per transaction. To read, the host sends the register index, issues a repeated START, addresses the target again with the read bit set, and receives one byte. The writable registers drive parallel outputs that feed the regulator's control logic. A high-speed master code at the head of a transaction is never acknowledged. It does switch the input deglitch filters to single-sample mode from the next repeated START until the next STOP. While the chip-enable input is low, the block is held in its default state and ignores the bus.

Top module: `vreg_i2c_target`

## Requirements
- R1: A write of the form START, 0xC0, index, data, STOP is acknowledged on all three bytes. The data byte is committed only after its eighth bit, and registers 0 and 1 accept all eight bits.
- R2: A read of the form START, 0xC0, index, repeated START, 0xC1 returns the indexed register MSB first. SDA is pulled low only for ACK bits and for zero data bits.
- R3: An address byte other than 0xC0 or 0xC1 gets no acknowledge and changes no register.
- R4: After reset, and for as long as chip enable is low, registers 0 and 1 read 0xAC (enable bit 7 set, code 44), register 2 reads 0x00 and SDA is released. While chip enable is low, no byte is acknowledged and no write takes effect.
- R5: In register 2, bits 7:4 are writable and bits 3:0 always read 0.
- R6: Register 3 reads 0x80 and register 4 reads 0x0C. Writes to either are acknowledged and discarded.
- R7: Register 5 returns the captured power-good input in bit 7, with bits 6:0 reading 0.
- R8: Indices 6 to 255 read 0x00. Writes to them are acknowledged and change nothing.
- R9: After a START from idle, a first byte of the form 00001xxx gets no acknowledge. The next repeated START sets high-speed mode, and the following STOP clears it.
- R10: A STOP that arrives partway through a data byte ends the transfer without writing anything.
- R11: In fast mode, a low pulse on SCL lasting one clock sample is filtered out and does not shift a bit.
- R12: A second data byte in a write transaction gets no acknowledge and is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| chip_en | input | 1 | Chip enable; low holds defaults and ignores the bus |
| scl_i | input | 1 | Sampled SCL pin |
| sda_i | input | 1 | Sampled SDA pin (wired bus level) |
| pgood_i | input | 1 | Power-good status, captured into register 5 |
| sda_pull_o | output | 1 | High to pull SDA low |
| hs_mode_o | output | 1 | High while the high-speed filter setting is in force |
| vset0_o | output | 8 | Register 0: enable, forced-PWM, 6-bit voltage code |
| vset1_o | output | 8 | Register 1: same layout as register 0 |
| ctrl_o | output | 8 | Register 2: discharge bit 7, slew code bits 6:4 |

## Verification
The bench writes and reads every index through the bus. A reserved nibble that stored data, or a read-only register that took a write, would show up as a wrong read-back value. It aborts a data byte with a STOP after four bits: a design that commits partial bytes would leave a shifted value in register 1. It injects a one-sample SCL glitch, which an unfiltered input would count as an extra bit. It also sends a master code and a second data byte, both of which must go unacknowledged, and it checks that chip enable low blocks acknowledges and restores the defaults.

// File: rtl/vreg_i2c_pkg.sv
// Shared types and register indices for the regulator serial-bus target.
// Assumes register indices are compared as full 8-bit values.
package vreg_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_WAIT
    } bus_state_t;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_REG,
        PH_DATA
    } phase_t;

    localparam logic [7:0] RA_VSET0 = 8'h00;
    localparam logic [7:0] RA_VSET1 = 8'h01;
    localparam logic [7:0] RA_CTRL  = 8'h02;
    localparam logic [7:0] RA_IDV   = 8'h03;
    localparam logic [7:0] RA_IDR   = 8'h04;
    localparam logic [7:0] RA_MON   = 8'h05;

    localparam logic [7:0] ID_VENDOR_VAL = 8'h80;
    localparam logic [7:0] ID_REV_VAL    = 8'h0C;

endpackage

// File: rtl/vreg_i2c_filter.sv
// Input conditioner for one bus line: a two-flop synchroniser, then a
// majority vote over DEPTH samples in fast mode, or the newest sample
// alone in high-speed mode. Assumes DEPTH is odd and at least 2.
module vreg_i2c_filter #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hs_mode,
    input  logic line_in,
    output logic line_out
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [1:0]       sync_q;
    logic [DEPTH-1:0] win_q;
    logic [CW-1:0]    ones;
    logic             vote;

    // Count the high samples in the window and take the majority.
    always_comb begin
        ones = '0;
        for (int i = 0; i < DEPTH; i++) begin
            ones = ones + CW'(win_q[i]);
        end
        vote = (ones > CW'(DEPTH / 2));
    end

    // Synchronise, shift the sample window and register the cleaned level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q   <= '1;
            win_q    <= '1;
            line_out <= 1'b1;
        end else begin
            sync_q   <= {sync_q[0], line_in};
            win_q    <= {win_q[DEPTH-2:0], sync_q[1]};
            line_out <= hs_mode ? win_q[0] : vote;
        end
    end

endmodule

// File: rtl/vreg_i2c_link.sv
// Bus protocol engine: detects START and STOP, shifts bytes in on SCL
// rising edges, drives ACK and read data after SCL falling edges, and
// recognises the high-speed master code without acknowledging it.
// Assumes scl and sda are already filtered and aligned to clk.
module vreg_i2c_link
    import vreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic       sda_pull,
    output logic       hs_mode,
    output logic [7:0] reg_ptr,
    output logic       wr_en,
    output logic [7:0] wr_data
);
    bus_state_t state;
    phase_t     phase;
    logic       scl_q, sda_q;
    logic [7:0] shreg, txsh;
    logic [3:0] bitcnt;
    logic       rw, fresh, hs_armed;
    logic       is_start, is_stop, scl_rise, scl_fall;

    // Classify bus events from the previous and current filtered levels.
    always_comb begin
        is_start = scl && scl_q && sda_q && !sda;
        is_stop  = scl && scl_q && !sda_q && sda;
        scl_rise = scl && !scl_q;
        scl_fall = !scl && scl_q;
    end

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    // Protocol state machine; STOP and START take priority over bit traffic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            phase    <= PH_DEV;
            shreg    <= '0;
            txsh     <= '0;
            bitcnt   <= '0;
            rw       <= 1'b0;
            fresh    <= 1'b0;
            hs_armed <= 1'b0;
            hs_mode  <= 1'b0;
            sda_pull <= 1'b0;
            reg_ptr  <= '0;
            wr_en    <= 1'b0;
            wr_data  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (is_stop) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                hs_mode  <= 1'b0;
                hs_armed <= 1'b0;
            end else if (is_start) begin
                state    <= ST_RX;
                phase    <= PH_DEV;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
                fresh    <= (state == ST_IDLE);
                if (hs_armed) begin
                    hs_mode  <= 1'b1;
                    hs_armed <= 1'b0;
                end
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            fresh <= 1'b0;
                            case (phase)
                                PH_DEV: begin
                                    if (fresh && shreg[7:3] == 5'b00001) begin
                                        hs_armed <= 1'b1;
                                        state    <= ST_WAIT;
                                    end else if (shreg[7:1] == DEV_ADDR) begin
                                        rw       <= shreg[0];
                                        sda_pull <= 1'b1;
                                        state    <= ST_ACK;
                                    end else begin
                                        state <= ST_WAIT;
                                    end
                                end
                                PH_REG: begin
                                    reg_ptr  <= shreg;
                                    sda_pull <= 1'b1;
                                    state    <= ST_ACK;
                                end
                                default: begin
                                    wr_en    <= 1'b1;
                                    wr_data  <= shreg;
                                    sda_pull <= 1'b1;
                                    state    <= ST_ACK;
                                end
                            endcase
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (phase == PH_DEV && rw) begin
                                txsh     <= rd_data;
                                sda_pull <= ~rd_data[7];
                                state    <= ST_TX;
                            end else begin
                                sda_pull <= 1'b0;
                                case (phase)
                                    PH_DEV:  begin phase <= PH_REG;  state <= ST_RX; end
                                    PH_REG:  begin phase <= PH_DATA; state <= ST_RX; end
                                    default: state <= ST_WAIT;
                                endcase
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_pull <= 1'b0;
                                state    <= ST_WAIT;
                            end else begin
                                sda_pull <= ~txsh[6];
                                txsh     <= {txsh[6:0], 1'b0};
                                bitcnt   <= bitcnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_HS_NEEDS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode) |-> $past(hs_armed)); // R9
    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_WAIT) |-> !sda_pull); // R2
    AST_WRITE_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(state == ST_RX && phase == PH_DATA && bitcnt == 4'd8)); // R10

endmodule

// File: rtl/vreg_i2c_regs.sv
// Register storage and read multiplexer for the regulator controls.
// Writable slots 0..2, fixed identification bytes 3..4, status slot 5.
// Assumes wr_en is a single-cycle strobe qualified by the protocol engine.
module vreg_i2c_regs
    import vreg_i2c_pkg::*;
#(
    parameter logic [5:0] DEF_VCODE = 6'd44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wr_data,
    input  logic       pgood_in,
    output logic [7:0] rd_data,
    output logic [7:0] vset0_q,
    output logic [7:0] vset1_q,
    output logic [7:0] ctrl_q
);
    localparam logic [7:0] VSET_DEF = {2'b10, DEF_VCODE};

    logic pg_q;

    // Store writes to the writable slots; other indices are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vset0_q <= VSET_DEF;
            vset1_q <= VSET_DEF;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_VSET0: vset0_q <= wr_data;
                RA_VSET1: vset1_q <= wr_data;
                RA_CTRL:  ctrl_q  <= {wr_data[7:4], 4'b0000};
                default: ;
            endcase
        end
    end

    // Capture the power-good status every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pg_q <= 1'b0;
        else        pg_q <= pgood_in;
    end

    // Select the byte returned for the current index.
    always_comb begin
        case (addr)
            RA_VSET0: rd_data = vset0_q;
            RA_VSET1: rd_data = vset1_q;
            RA_CTRL:  rd_data = ctrl_q;
            RA_IDV:   rd_data = ID_VENDOR_VAL;
            RA_IDR:   rd_data = ID_REV_VAL;
            RA_MON:   rd_data = {pg_q, 7'b0};
            default:  rd_data = 8'h00;
        endcase
    end

    AST_VSET0_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == RA_VSET0) |=> vset0_q == $past(wr_data)); // R1
    AST_RO_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr > RA_CTRL) |=> ($stable(vset0_q) && $stable(vset1_q) && $stable(ctrl_q))); // R6

endmodule

// File: rtl/vreg_i2c_target.sv
// Top level: two line filters, the protocol engine and the register file.
// Chip enable low acts as a reset for everything inside the block.
// Assumes scl_i and sda_i carry the wired bus levels.
module vreg_i2c_target #(
    parameter logic [6:0] DEV_ADDR  = 7'h60,
    parameter int         FLT_DEPTH = 3,
    parameter logic [5:0] DEF_VCODE = 6'd44
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chip_en,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       pgood_i,
    output logic       sda_pull_o,
    output logic       hs_mode_o,
    output logic [7:0] vset0_o,
    output logic [7:0] vset1_o,
    output logic [7:0] ctrl_o
);
    localparam logic [7:0] VSET_DEF = {2'b10, DEF_VCODE};

    logic       live_n;
    logic       scl_f, sda_f;
    logic [7:0] rd_data, reg_ptr, wr_data;
    logic       wr_en;

    assign live_n = rst_n & chip_en;

    vreg_i2c_filter #(.DEPTH(FLT_DEPTH)) u_scl_flt (
        .clk(clk), .rst_n(live_n), .hs_mode(hs_mode_o),
        .line_in(scl_i), .line_out(scl_f)
    );

    vreg_i2c_filter #(.DEPTH(FLT_DEPTH)) u_sda_flt (
        .clk(clk), .rst_n(live_n), .hs_mode(hs_mode_o),
        .line_in(sda_i), .line_out(sda_f)
    );

    vreg_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
        .clk(clk), .rst_n(live_n), .scl(scl_f), .sda(sda_f),
        .rd_data(rd_data), .sda_pull(sda_pull_o), .hs_mode(hs_mode_o),
        .reg_ptr(reg_ptr), .wr_en(wr_en), .wr_data(wr_data)
    );

    vreg_i2c_regs #(.DEF_VCODE(DEF_VCODE)) u_regs (
        .clk(clk), .rst_n(live_n), .wr_en(wr_en), .addr(reg_ptr),
        .wr_data(wr_data), .pgood_in(pgood_i), .rd_data(rd_data),
        .vset0_q(vset0_o), .vset1_q(vset1_o), .ctrl_q(ctrl_o)
    );

    AST_OFF_HOLDS_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_en |=> (vset0_o == VSET_DEF && vset1_o == VSET_DEF && !sda_pull_o && !hs_mode_o)); // R4

endmodule

// File: tb/vreg_i2c_target_test.sv
`timescale 1ns/1ps
module vreg_i2c_target_test;
    localparam int H = 16;
    localparam int G = 6;
    localparam int NV = 10;
    // {is_write, index, write data, expected read-back}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'h00, 8'h55, 8'h55},
        {1'b1, 8'h01, 8'h3F, 8'h3F},
        {1'b1, 8'h02, 8'hFF, 8'hF0},
        {1'b1, 8'h03, 8'h12, 8'h80},
        {1'b1, 8'h04, 8'hAA, 8'h0C},
        {1'b1, 8'h07, 8'h77, 8'h00},
        {1'b0, 8'h05, 8'h00, 8'h00},
        {1'b1, 8'h00, 8'h80, 8'h80},
        {1'b1, 8'h02, 8'h5A, 8'h50},
        {1'b0, 8'h01, 8'h00, 8'h3F}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_en = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pgood = 1'b0;
    logic sda_line;
    logic sda_pull, hs_mode;
    logic [7:0] vset0, vset1, ctrl;
    int vectors = 0;
    int miscompares = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    vreg_i2c_target uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .scl_i(scl_m),
        .sda_i(sda_line), .pgood_i(pgood), .sda_pull_o(sda_pull),
        .hs_mode_o(hs_mode), .vset0_o(vset0), .vset1_o(vset1), .ctrl_o(ctrl)
    );

    task automatic hw(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(G);
    endtask

    task automatic bus_rstart();
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b0; hw(H);
        scl_m = 1'b0; hw(G);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hw(H);
        scl_m = 1'b1; hw(H);
        sda_m = 1'b1; hw(H);
    endtask

    // Send a byte; gbit selects a bit that gets a one-sample SCL glitch.
    task automatic send_byte(input logic [7:0] b, input int gbit, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hw(H);
            scl_m = 1'b1;
            if (i == gbit) begin
                hw(H/2); scl_m = 1'b0; hw(1); scl_m = 1'b1; hw(H/2 - 1);
            end else begin
                hw(H);
            end
            scl_m = 1'b0; hw(G);
        end
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H/2);
        ack = !sda_line;
        hw(H/2);
        scl_m = 1'b0; hw(G);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw(H);
            scl_m = 1'b1; hw(H/2);
            b[i] = sda_line;
            hw(H/2);
            scl_m = 1'b0; hw(G);
        end
        sda_m = 1'b1; hw(H);
        scl_m = 1'b1; hw(H);
        scl_m = 1'b0; hw(G);
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d, input int gbit,
                             output logic [2:0] acks);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hC0, -1, a0);
        send_byte(idx, -1, a1);
        send_byte(d, gbit, a2);
        bus_stop();
        acks = {a0, a1, a2};
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d, output logic [2:0] acks);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hC0, -1, a0);
        send_byte(idx, -1, a1);
        bus_rstart();
        send_byte(8'hC1, -1, a2);
        recv_byte(d);
        bus_stop();
        acks = {a0, a1, a2};
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [2:0] acks;
        logic a;
        hw(10);
        rst_n = 1'b1;
        hw(4);
        // R4: reset state
        check("R4 vset0 reset", vset0, 8'hAC);
        check("R4 vset1 reset", vset1, 8'hAC);
        check("R4 ctrl reset", ctrl, 8'h00);
        check("R4 sda released", {7'b0, sda_pull}, 8'h00);

        // Table walk: writes (with read-back) and plain reads.
        for (int k = 0; k < NV; k++) begin
            logic [7:0] idx, wd, ex;
            string tag;
            idx = VEC[k][23:16]; wd = VEC[k][15:8]; ex = VEC[k][7:0];
            if (idx < 8'd2)       tag = "R1";
            else if (idx == 8'd2) tag = "R5";
            else if (idx < 8'd5)  tag = "R6";
            else if (idx == 8'd5) tag = "R7";
            else                  tag = "R8";
            if (VEC[k][24]) begin
                reg_write(idx, wd, -1, acks);
                check({tag, " write acks"}, {5'b0, acks}, 8'h07);
            end
            reg_read(idx, rd, acks);
            check("R2 read acks", {5'b0, acks}, 8'h07);
            check({tag, " read-back"}, rd, ex);
        end
        check("R1 vset0 output", vset0, 8'h80);
        check("R5 ctrl output", ctrl, 8'h50);

        // R7: power-good captured into bit 7
        pgood = 1'b1;
        reg_read(8'h05, rd, acks);
        check("R7 power good high", rd, 8'h80);

        // R3: foreign address is ignored
        bus_start();
        send_byte(8'hC2, -1, a);
        bus_stop();
        check("R3 foreign address ack", {7'b0, a}, 8'h00);
        check("R3 vset0 unchanged", vset0, 8'h80);

        // R10: STOP after four data bits, nothing written
        bus_start();
        send_byte(8'hC0, -1, a);
        send_byte(8'h01, -1, a);
        for (int i = 7; i >= 4; i--) begin
            sda_m = 1'b0; hw(H);
            scl_m = 1'b1; hw(H);
            scl_m = 1'b0; hw(G);
        end
        bus_stop();
        reg_read(8'h01, rd, acks);
        check("R10 aborted byte not written", rd, 8'h3F);

        // R12: second data byte is refused
        bus_start();
        send_byte(8'hC0, -1, a);
        send_byte(8'h01, -1, a);
        send_byte(8'h11, -1, a);
        send_byte(8'h22, -1, a);
        bus_stop();
        check("R12 extra byte ack", {7'b0, a}, 8'h00);
        check("R12 first byte kept", vset1, 8'h11);

        // R11: one-sample SCL glitch in fast mode
        reg_write(8'h00, 8'h33, 3, acks);
        check("R11 glitch write acks", {5'b0, acks}, 8'h07);
        check("R11 glitch rejected", vset0, 8'h33);

        // R9: master code, high-speed entry and exit
        bus_start();
        send_byte(8'h09, -1, a);
        check("R9 master code not acked", {7'b0, a}, 8'h00);
        bus_rstart();
        check("R9 high-speed entered", {7'b0, hs_mode}, 8'h01);
        send_byte(8'hC0, -1, a);
        check("R9 address acked in hs", {7'b0, a}, 8'h01);
        send_byte(8'h01, -1, a);
        send_byte(8'h2A, -1, a);
        bus_stop();
        check("R9 high-speed left on stop", {7'b0, hs_mode}, 8'h00);
        check("R9 hs write", vset1, 8'h2A);

        // R4: chip enable low restores defaults and blocks the bus
        chip_en = 1'b0;
        hw(3);
        check("R4 off vset0", vset0, 8'hAC);
        check("R4 off ctrl", ctrl, 8'h00);
        bus_start();
        send_byte(8'hC0, -1, a);
        bus_stop();
        check("R4 no ack when off", {7'b0, a}, 8'h00);
        chip_en = 1'b1;
        hw(4);
        reg_read(8'h01, rd, acks);
        check("R4 default after enable", rd, 8'hAC);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule